// File: doc/BRIEF.md
# Serial Segment Row Loader

This block accepts display data for an 80-segment multiplexed LCD over a three-wire serial link: a data line, a shift clock and a load strobe. All three lines are sampled in the system clock through two-flop synchronizers. Each detected rising edge of the synchronized shift clock moves one data bit into an 88-bit shift register. The first 80 bits of a frame are segment data. The last 8 bits are a row-select code that chooses one of five 80-bit row latches, one for each common phase of the display.

While the synchronized load strobe is high, the selected row latch follows the data part of the shift register on every system clock. When the strobe falls, the latch holds its value. A code that names no row leaves every latch untouched. All five rows are presented side by side to a downstream display scanner. A stored 1 turns its segment on and a stored 0 turns it off, one bit per segment.

Top module: `serial_row_loader`

## Requirements
- R1: While reset is asserted, every row output bit is 0, so every segment is off.
- R2: The shift register moves by exactly one bit for each rising edge of the serial clock. Changes on the data line while the serial clock stays low, and falling edges of the serial clock, shift nothing.
- R3: Of an 88-bit frame, the first bit shifted lands on segment 80, which is row bit 79. The 80th bit lands on segment 1, which is row bit 0. Every row bit drives its own segment, with 1 meaning on.
- R4: The last 8 bits shifted form the select code, most significant bit first. A code c in the range 1 to 5 writes row c-1, which is output on `rows_o[(c-1)*80 +: 80]`.
- R5: While the load strobe is high, the selected row follows the shift register, so bits shifted during the strobe reach the latch.
- R6: While the load strobe is low, no row changes, even while new frames are shifted in.
- R7: Select codes 0 and 6 to 255 change no row when the load strobe is high.
- R8: A load into one row leaves the other four rows unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock, asynchronous |
| ser_dat_i | input | 1 | Serial data bit |
| ser_ld_i | input | 1 | Level-sensitive load strobe |
| rows_o | output | 400 | Five 80-bit rows; row r is at bits r*80 and up |

## Verification
Frames are sent for select codes 0 through 15 and for 255, each with arithmetic data patterns. This separates the five valid codes from the invalid ones and shows that each valid code writes only its own row. A frame with a single leading 1 fixes the bit-to-segment order. Toggling the data line with the serial clock held low shows that only rising clock edges shift. A frame shifted while the strobe is held high shows that the load is transparent. A frame shifted with the strobe low shows that the latches hold.

// File: rtl/loader_pkg.sv
package loader_pkg;
    parameter int unsigned DEF_ROW_W  = 80;
    parameter int unsigned DEF_SEL_W  = 8;
    parameter int unsigned DEF_ROWS   = 5;
    parameter int unsigned DEF_STAGES = 2;
endpackage

// File: rtl/loader_sync.sv
module loader_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = loader_pkg::DEF_STAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o,
    output logic [W-1:0] rise_o
);
    // one stage beyond the synchronizer holds the previous value for edge detection
    typedef struct packed {
        logic [STAGES:0][W-1:0] chain;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = d_i;
        for (int i = 1; i <= STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o    = st_q.chain[STAGES-1];
    assign rise_o = st_q.chain[STAGES-1] & ~st_q.chain[STAGES];
endmodule

// File: rtl/loader_shift.sv
module loader_shift #(
    parameter int unsigned SR_W = 88
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            bit_i,
    output logic [SR_W-1:0] sr_o
);
    typedef struct packed {
        logic [SR_W-1:0] sr;
    } shift_t;

    shift_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (en_i) sh_d.sr = {sh_q.sr[SR_W-2:0], bit_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sr_o = sh_q.sr;
endmodule

// File: rtl/loader_rowbank.sv
module loader_rowbank #(
    parameter int unsigned ROW_W = loader_pkg::DEF_ROW_W,
    parameter int unsigned SEL_W = loader_pkg::DEF_SEL_W,
    parameter int unsigned ROWS  = loader_pkg::DEF_ROWS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld_i,
    input  logic [ROW_W+SEL_W-1:0] sr_i,
    output logic [ROWS-1:0]       wr_en_o,
    output logic [ROWS*ROW_W-1:0] rows_o
);
    localparam int unsigned SR_W = ROW_W + SEL_W;

    typedef struct packed {
        logic [ROWS-1:0][ROW_W-1:0] row;
    } bank_t;

    bank_t bk_d, bk_q;
    logic [SEL_W-1:0] code;
    logic [ROW_W-1:0] payload;

    assign code    = sr_i[SEL_W-1:0];
    assign payload = sr_i[SR_W-1:SEL_W];

    for (genvar r = 0; r < ROWS; r++) begin : g_dec
        assign wr_en_o[r] = ld_i && (code == SEL_W'(r + 1));
    end

    always_comb begin
        bk_d = bk_q;
        for (int r = 0; r < ROWS; r++) begin
            if (wr_en_o[r]) bk_d.row[r] = payload;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign rows_o = bk_q.row;
endmodule

// File: rtl/serial_row_loader.sv
module serial_row_loader #(
    parameter int unsigned ROW_W  = loader_pkg::DEF_ROW_W,
    parameter int unsigned SEL_W  = loader_pkg::DEF_SEL_W,
    parameter int unsigned ROWS   = loader_pkg::DEF_ROWS,
    parameter int unsigned STAGES = loader_pkg::DEF_STAGES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ser_clk_i,
    input  logic                  ser_dat_i,
    input  logic                  ser_ld_i,
    output logic [ROWS*ROW_W-1:0] rows_o
);
    localparam int unsigned SR_W = ROW_W + SEL_W;

    logic [2:0]      sync_q, sync_rise;
    logic            shift_en, dat_sync, ld_sync;
    logic [SR_W-1:0] sr_q;
    logic [ROWS-1:0] wr_en;

    loader_sync #(.W(3), .STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_i({ser_ld_i, ser_dat_i, ser_clk_i}),
        .q_o(sync_q), .rise_o(sync_rise)
    );

    assign shift_en = sync_rise[0];
    assign dat_sync = sync_q[1];
    assign ld_sync  = sync_q[2];

    loader_shift #(.SR_W(SR_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .en_i(shift_en), .bit_i(dat_sync), .sr_o(sr_q)
    );

    loader_rowbank #(.ROW_W(ROW_W), .SEL_W(SEL_W), .ROWS(ROWS)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .ld_i(ld_sync), .sr_i(sr_q),
        .wr_en_o(wr_en), .rows_o(rows_o)
    );
endmodule

// File: rtl/loader_checker.sv
module loader_checker #(
    parameter int unsigned ROW_W = 80,
    parameter int unsigned SEL_W = 8,
    parameter int unsigned ROWS  = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [ROWS*ROW_W-1:0]   rows,
    input logic                    ld,
    input logic                    din,
    input logic                    shift_en,
    input logic [ROW_W+SEL_W-1:0]  sr,
    input logic [ROWS-1:0]         wr_en
);
    localparam int unsigned SR_W = ROW_W + SEL_W;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> rows == '0);

    assert_shift_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (sr[0] == $past(din)) && (sr[SR_W-1:1] == $past(sr[SR_W-2:0])));

    assert_no_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(sr));

    assert_hold_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(rows));

    assert_bad_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ld && (sr[SEL_W-1:0] == '0 || sr[SEL_W-1:0] > SEL_W'(ROWS)) |=> $stable(rows));

    assert_single_row_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en));

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assert_row_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ld && sr[SEL_W-1:0] == SEL_W'(r + 1)
            |=> rows[r*ROW_W +: ROW_W] == $past(sr[SR_W-1:SEL_W]));
    end
endmodule

bind serial_row_loader loader_checker #(.ROW_W(ROW_W), .SEL_W(SEL_W), .ROWS(ROWS)) u_chk (
    .clk(clk), .rst_n(rst_n), .rows(rows_o), .ld(ld_sync), .din(dat_sync),
    .shift_en(shift_en), .sr(sr_q), .wr_en(wr_en)
);

// File: tb/serial_row_loader_test.sv
module serial_row_loader_test;
    logic clk = 0;
    logic rst_n = 0;
    logic ser_clk = 0, ser_dat = 0, ser_ld = 0;
    logic [399:0] rows_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [87:0] m_sr = '0;
    logic [79:0] m_rows [5];

    always #10 clk = ~clk;

    serial_row_loader uut (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
        .ser_ld_i(ser_ld), .rows_o(rows_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
            $finish;
        end
    end

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic model_apply();
        int c;
        c = int'(m_sr[7:0]);
        if (c >= 1 && c <= 5) m_rows[c-1] = m_sr[87:8];
    endtask

    task automatic send_bit(input logic b);
        ser_dat = b;
        wait_clk(3);
        ser_clk = 1;
        wait_clk(3);
        ser_clk = 0;
        wait_clk(3);
        m_sr = {m_sr[86:0], b};
        if (ser_ld) model_apply();
    endtask

    task automatic send_frame(input logic [79:0] d, input logic [7:0] c);
        logic [87:0] f;
        f = {d, c};
        for (int i = 87; i >= 0; i--) send_bit(f[i]);
    endtask

    task automatic pulse_load();
        ser_ld = 1;
        model_apply();
        wait_clk(6);
        ser_ld = 0;
        wait_clk(6);
    endtask

    task automatic check_rows(input string tag);
        for (int r = 0; r < 5; r++) begin
            checks++;
            if (rows_o[r*80 +: 80] !== m_rows[r]) begin
                fails++;
                $display("FAIL %s row %0d: actual=%h expected=%h", tag, r,
                         rows_o[r*80 +: 80], m_rows[r]);
            end
        end
    endtask

    task automatic check_bit(input string tag, input int idx, input logic exp);
        checks++;
        if (rows_o[idx] !== exp) begin
            fails++;
            $display("FAIL %s bit %0d: actual=%b expected=%b", tag, idx, rows_o[idx], exp);
        end
    endtask

    initial begin
        logic [79:0] pat;
        for (int r = 0; r < 5; r++) m_rows[r] = '0;
        wait_clk(4);
        check_rows("R1 reset");
        rst_n = 1;
        wait_clk(4);

        // R3: single leading 1 lands on segment 80 of row 0; trailing 1 on segment 1 of row 1
        send_frame({1'b1, 79'd0}, 8'd1);
        pulse_load();
        check_bit("R3 first-bit", 79, 1'b1);
        check_bit("R3 first-bit", 78, 1'b0);
        send_frame(80'd1, 8'd2);
        pulse_load();
        check_bit("R3 last-data-bit", 80, 1'b1);
        check_bit("R3 last-data-bit", 159, 1'b0);
        check_rows("R3");

        // R4/R7/R8: sweep codes 0..15 and 255 with arithmetic patterns
        for (int c = 0; c < 17; c++) begin
            logic [7:0] code;
            code = (c == 16) ? 8'hFF : 8'(c);
            pat = {5{16'(c * 16'h9E37 + 16'h1234)}} ^ {80'(c) << (c * 4)};
            send_frame(pat, code);
            pulse_load();
            if (code >= 1 && code <= 5) check_rows("R4/R8 valid code");
            else check_rows("R7 invalid code");
        end

        // R2: data toggles with serial clock low shift nothing
        send_frame(80'hA5A5_5A5A_F0F0_0F0F_1234, 8'd3);
        for (int k = 0; k < 6; k++) begin
            ser_dat = ~ser_dat;
            wait_clk(4);
        end
        pulse_load();
        check_rows("R2 no-edge");

        // R6: frame shifted with load low changes nothing
        send_frame(80'hFFFF_FFFF_FFFF_FFFF_FFFF, 8'd3);
        wait_clk(6);
        check_rows("R6 hold");

        // R5: load held high while a further frame is shifted
        send_frame(80'h0123_4567_89AB_CDEF_0246, 8'd5);
        ser_ld = 1;
        model_apply();
        wait_clk(6);
        send_frame(80'h1357_9BDF_2468_ACE0_FEDC, 8'd5);
        wait_clk(6);
        ser_ld = 0;
        wait_clk(6);
        check_rows("R5 transparent");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule